// File: doc/BRIEF.md
# Card Clock Generator with Buffer-Driven Gating

This block derives the serial clock for a memory card from the system clock. An 8-bit divider value sets the clock. A power-save mode divides it further by a 3-bit exponent-based factor. The clock can also be held still while the data buffer cannot keep up. When a read is in progress and the buffer is full, the clock stops. When a write is in progress and the buffer has no data to send, the clock stops. Each of these two holds has its own enable bit.

The generated clock is a registered level, so it has no glitches. It only stops or resumes during its low phase. A high phase is therefore never shortened, and a low phase is never shortened either. A new divider setting is taken at the start of a clock period, which is the rising edge of the card clock. The block also drives a one-cycle strobe in the system-clock cycle before each card-clock transition. Downstream command and data logic can use this strobe as a clock enable. A configuration error flag reports a power-save request that carries a zero exponent.

Top module: `card_clk_gen`

## Requirements
- R1: In normal mode, with divider value D on `div_val`, the high phase and the low phase of `card_clk` each last D+1 system-clock cycles. The period is therefore 2*(D+1) cycles.
- R2: With `psv_en`=1 and a nonzero exponent P on `psv_div`, each phase lasts (D+1)*((2^P)+1) cycles.
- R3: With `psv_en`=1 and `psv_div`=0, the clock stays at the normal-mode rate. `cfg_err` reads 1 from the cycle after the condition appears, and returns to 0 the cycle after the condition goes away.
- R4: With `rd_proof_en`=1, `xfer_act`=1 and `xfer_rd`=1 (1 means read), `card_clk` is held low while `buf_full`=1.
- R5: With `wr_proof_en`=1, `xfer_act`=1 and `xfer_rd`=0 (write), `card_clk` is held low while `buf_empty`=1.
- R6: A proof enable at 0 disables its hold. A buffer flag that does not match the transfer direction has no effect. In both cases the period stays as in R1.
- R7: A hold requested during a high phase lets that phase run to its full length before the clock stops low. When the hold is released after the low count has run out, `card_clk` rises on the next system-clock edge.
- R8: A change of `div_val` made during a period does not change that period. It applies from the next rising edge of `card_clk`.
- R9: `edge_pulse` is 1 exactly in the system-clock cycles after which `card_clk` changes level. It is 0 in every cycle in which the clock is held.
- R10: After reset, `card_clk`, `edge_pulse` and `cfg_err` are 0. While `clk_en`=0, `card_clk` stays low once any high phase in progress has ended. After `clk_en` returns to 1, a full low phase comes before the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Enables card clock generation |
| div_val | input | 8 | Divider value D |
| psv_div | input | 3 | Power-save exponent P |
| psv_en | input | 1 | Power-save mode request |
| rd_proof_en | input | 1 | Hold the clock on a full buffer during reads |
| wr_proof_en | input | 1 | Hold the clock on an empty buffer during writes |
| xfer_act | input | 1 | A data transfer is in progress |
| xfer_rd | input | 1 | Transfer direction: 1 read, 0 write |
| buf_full | input | 1 | Data buffer is full |
| buf_empty | input | 1 | Data buffer is empty |
| card_clk | output | 1 | Generated card clock |
| edge_pulse | output | 1 | Strobe in the cycle before each card clock transition |
| cfg_err | output | 1 | Power-save requested with a zero exponent |

## Verification
The hardest case to reach from the ports is a hold that arrives while `card_clk` is high. The high phase must finish at full length, and the clock must then rise exactly one cycle after the release. The bench reaches this case by waiting for a sampled rising edge and raising the buffer flag at that same falling system-clock edge. It then times the high phase and checks every cycle of the hold before it releases. Divider changes in mid-period are made the same way, anchored to an observed rising edge, so the old and new phase lengths can be told apart.

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W = 8,
  parameter int PSD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PSD_W-1:0] psv_div,
  input  logic             psv_en,
  input  logic             rd_proof_en,
  input  logic             wr_proof_en,
  input  logic             xfer_act,
  input  logic             xfer_rd,
  input  logic             buf_full,
  input  logic             buf_empty,
  output logic             card_clk,
  output logic             edge_pulse,
  output logic             cfg_err
);

  localparam int MW = 1 << PSD_W;
  localparam int CW = DIV_W + 1 + MW;

  logic          run;
  logic [CW-1:0] cnt, cur_half, half_new;
  logic [DIV_W:0] dplus;
  logic [MW-1:0] pmul;
  logic          ps_ok, stall, at_end;

  assign ps_ok    = psv_en && (psv_div != '0);
  assign dplus    = {1'b0, div_val} + 1'b1;
  assign pmul     = ps_ok ? (MW'(1) << psv_div) + MW'(1) : MW'(1);
  assign half_new = CW'(dplus) * CW'(pmul);

  assign stall = xfer_act && ((xfer_rd && rd_proof_en && buf_full) ||
                              (!xfer_rd && wr_proof_en && buf_empty));

  assign at_end     = run && (cnt == '0);
  assign edge_pulse = at_end && (card_clk || (clk_en && !stall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      card_clk <= 1'b0;
      cnt      <= '0;
      cur_half <= CW'(1);
    end else if (!run) begin
      card_clk <= 1'b0;
      if (clk_en) begin
        run      <= 1'b1;
        cur_half <= half_new;
        cnt      <= half_new - CW'(1);
      end
    end else if (!clk_en && !card_clk) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end else if (edge_pulse) begin
      card_clk <= !card_clk;
      if (card_clk) begin
        cnt <= cur_half - CW'(1);
      end else begin
        cur_half <= half_new;
        cnt      <= half_new - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= psv_en && (psv_div == '0);
  end

  a_r3_zero_exp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (psv_en && psv_div == '0) |=> cfg_err);

  a_r5_hold_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_clk && stall && clk_en) |=> !card_clk);

  a_r9_no_pulse_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_clk && stall) |-> !edge_pulse);

  a_r9_pulse_then_edge: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> (card_clk != $past(card_clk)));

  a_r9_edge_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk != $past(card_clk)) |-> $past(edge_pulse));

  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !card_clk) |=> !card_clk);

endmodule

// File: tb/card_clk_gen_tb_top.sv
module card_clk_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 0, psv_en = 0, rd_proof_en = 0, wr_proof_en = 0;
  logic xfer_act = 0, xfer_rd = 0, buf_full = 0, buf_empty = 0;
  logic [7:0] div_val = 0;
  logic [2:0] psv_div = 0;
  logic card_clk, edge_pulse, cfg_err;

  int n_chk = 0, n_fail = 0, pulse_err = 0, cyc = 0;
  logic prev_clk = 0, prev_pe = 0;

  always #5 clk = !clk;

  card_clk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_val(div_val),
    .psv_div(psv_div), .psv_en(psv_en), .rd_proof_en(rd_proof_en),
    .wr_proof_en(wr_proof_en), .xfer_act(xfer_act), .xfer_rd(xfer_rd),
    .buf_full(buf_full), .buf_empty(buf_empty), .card_clk(card_clk),
    .edge_pulse(edge_pulse), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_half(input int d, input int p, input bit ps);
    return (d + 1) * ((ps && p != 0) ? ((1 << p) + 1) : 1);
  endfunction

  // R9 monitor: a strobe must precede every change and only changes
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pe && card_clk == prev_clk) pulse_err++;
      if (!prev_pe && card_clk != prev_clk) pulse_err++;
    end
    prev_clk = card_clk;
    prev_pe  = edge_pulse;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(0, "watchdog", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_rise();
    bit p;
    p = card_clk;
    forever begin
      @(negedge clk);
      if (card_clk && !p) break;
      p = card_clk;
    end
  endtask

  task automatic count_level(input bit lvl, output int n);
    n = 0;
    while (card_clk == lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    count_level(1'b1, hi);
    count_level(1'b0, lo);
  endtask

  task automatic hold_check(input string tag, input int n);
    bit ok;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      if (card_clk || edge_pulse) ok = 0;
      @(negedge clk);
    end
    chk(ok, tag, card_clk, 0);
  endtask

  initial begin
    int hi, lo, h, d, p, n;
    bit ps;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(card_clk == 0, "R10 reset clk", card_clk, 0);
    chk(edge_pulse == 0, "R10 reset pulse", edge_pulse, 0);
    chk(cfg_err == 0, "R10 reset err", cfg_err, 0);
    repeat (10) @(negedge clk);
    chk(card_clk == 0, "R10 idle before enable", card_clk, 0);

    // R1 directed corners
    clk_en = 1;
    div_val = 0;
    measure(hi, lo);
    chk(hi == 1 && lo == 1, "R1 div0", hi * 1000 + lo, 1001);
    div_val = 255;
    wait_rise();
    measure(hi, lo);
    chk(hi == 256 && lo == 256, "R1 div255", hi * 1000 + lo, 256256);

    // R1/R2 random mix
    for (int i = 0; i < 10; i++) begin
      d = $urandom % 16; p = $urandom % 8; ps = 1'($urandom % 2);
      div_val = 8'(d); psv_div = 3'(p); psv_en = ps;
      wait_rise();
      measure(hi, lo);
      h = exp_half(d, p, ps);
      chk(hi == h, ps ? "R2 high phase" : "R1 high phase", hi, h);
      chk(lo == h, ps ? "R2 low phase" : "R1 low phase", lo, h);
    end
    div_val = 0; psv_div = 7; psv_en = 1;
    wait_rise();
    measure(hi, lo);
    chk(hi == 129 && lo == 129, "R2 max exponent", hi, 129);

    // R3 zero exponent
    div_val = 2; psv_div = 0; psv_en = 1;
    @(negedge clk);
    chk(cfg_err == 1, "R3 err set", cfg_err, 1);
    wait_rise();
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R3 stays normal", hi * 10 + lo, 33);
    psv_en = 0;
    @(negedge clk);
    chk(cfg_err == 0, "R3 err clear", cfg_err, 0);

    // R8 divider change mid-period
    div_val = 3;
    wait_rise();
    wait_rise();
    div_val = 6;
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    chk(hi == 4 && lo == 4, "R8 old period kept", hi * 10 + lo, 44);
    count_level(1'b1, hi);
    chk(hi == 7, "R8 new period", hi, 7);

    // R4 + R7 read hold raised during high phase
    div_val = 2;
    xfer_act = 1; xfer_rd = 1; rd_proof_en = 1;
    wait_rise();
    wait_rise();
    buf_full = 1;
    count_level(1'b1, hi);
    chk(hi == 3, "R7 high not cut", hi, 3);
    hold_check("R4 read hold", 30);
    buf_full = 0;
    @(negedge clk);
    chk(card_clk == 1, "R7 resume next cycle", card_clk, 1);

    // R5 write hold
    xfer_rd = 0; rd_proof_en = 0; wr_proof_en = 1;
    wait_rise();
    buf_empty = 1;
    count_level(1'b1, hi);
    chk(hi == 3, "R5 high not cut", hi, 3);
    hold_check("R5 write hold", 25);
    buf_empty = 0;
    @(negedge clk);
    chk(card_clk == 1, "R5 resume", card_clk, 1);

    // R6 disabled or mismatched holds have no effect
    wr_proof_en = 0; rd_proof_en = 0; buf_full = 1; buf_empty = 1;
    xfer_rd = 1;
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R6 proofs off", hi * 10 + lo, 33);
    rd_proof_en = 1; wr_proof_en = 1; buf_full = 0; buf_empty = 1; xfer_rd = 1;
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R6 empty during read", hi * 10 + lo, 33);
    buf_full = 1; buf_empty = 0; xfer_rd = 0;
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R6 full during write", hi * 10 + lo, 33);
    buf_full = 0; rd_proof_en = 0; wr_proof_en = 0; xfer_act = 0;

    // R10 disable and restart
    div_val = 4;
    wait_rise();
    wait_rise();
    clk_en = 0;
    count_level(1'b1, hi);
    chk(hi == 5, "R10 high finishes", hi, 5);
    hold_check("R10 idle low", 40);
    clk_en = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!card_clk && n < 100);
    chk(n == 6, "R10 full low before first rise", n, 6);

    chk(pulse_err == 0, "R9 strobe vs edges", pulse_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule